// File: doc/BRIEF.md
# Configuration Clock Burst Counter

This block produces a finite train of configuration clock pulses on request. After a configuration data stream has been pushed into a device, the device typically needs a handful of extra clock edges before it enters user mode. Software supplies that clocking by writing a pulse count into the block. The block then toggles its clock output that many times and raises a sticky completion flag, which software polls and then clears.

Access is through a simple 32-bit register port with a single-cycle write strobe and a read strobe whose data returns one clock later. The count register and the status register sit at fixed byte offsets. Each pulse lasts two block clocks, one high and one low, so a burst of four pulses finishes eight clocks after the write. A count of zero completes at once. Writing a new count while a burst is running abandons the old burst and starts the new one.

Top module: `cfg_clk_burst`

## Requirements
- R1: After synchronous reset, `dclk_out`, `burst_busy` and the completion flag are 0, and a read of the count register returns 0.
- R2: A write of a nonzero value N to byte offset 0x8 starts a burst: `burst_busy` is 1 from the next clock, and exactly N pulses appear on `dclk_out`.
- R3: Counting from the clock edge that captures the write as edge 0, `dclk_out` is high after the odd edges 1, 3, ..., 2N-1 and low after all other edges. Each high phase lasts exactly one clock.
- R4: At edge 2N, `burst_busy` falls and the completion flag (status register at offset 0xc, bit 0) rises in the same cycle. The two are never 1 together.
- R5: A write of 0 to offset 0x8 sets the completion flag at the next edge, leaves `burst_busy` at 0 and emits no pulse.
- R6: A write to offset 0xc with data bit 0 set clears the completion flag. A write with bit 0 clear leaves the flag unchanged.
- R7: A count write during a running burst restarts the burst with the new count. `dclk_out` goes low, the completion flag stays 0, and the pulse pattern of R3 starts again from that write.
- R8: A read returns its data on `reg_rdata`, with `reg_rvalid` high, one clock after the strobe. Offset 0x8 gives the number of pulses not yet finished, as it was before that edge. Offset 0xc gives the completion flag in bit 0 and zeros elsewhere.
- R9: Reads of any other offset return 0. Writes to any other offset change nothing.
- R10: Only the low CNT_W bits (16 by default) of a count write are used. The higher bits are ignored, and this applies to the zero test of R5 as well.
- R11: If a clearing write to the status register lands on the same edge that completes a burst, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte offset of the access |
| reg_wdata | input | REG_W (32) | Write data |
| reg_rdata | output | REG_W (32) | Read data, registered |
| reg_rvalid | output | 1 | High for one clock when `reg_rdata` holds a read result |
| dclk_out | output | 1 | Configuration clock pulse output, registered |
| burst_busy | output | 1 | High while a burst is in progress, registered |

## Verification
The bench treats the edge that captures a count write as edge 0. It then samples `dclk_out`, `burst_busy` and the flag at every falling clock edge up to edge 2N+2, and compares each sample with the level that R3 and R4 give for that edge. Read results are due one edge after the strobe, so each read is issued right after a falling edge and sampled at the next falling edge. The bench expects the value the register held before the capturing edge. Collision cases, the restart and the flag clear that coincides with completion, are placed on exact edges by counting falling edges from the triggering write.

// File: rtl/cb_pkg.sv
package cb_pkg;
  localparam int unsigned OFS_COUNT  = 32'h8;
  localparam int unsigned OFS_STATUS = 32'hC;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cb_regif.sv
module cb_regif
  import cb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  cur_remaining,
  input  logic              cur_done,
  output logic              load_go,
  output logic [CNT_W-1:0]  load_val,
  output logic              w1c_go,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  reg_sel_e sel;

  always_comb begin
    if (reg_addr == A_COUNT)       sel = SEL_COUNT;
    else if (reg_addr == A_STATUS) sel = SEL_STATUS;
    else                           sel = SEL_NONE;
  end

  assign load_go  = reg_wr && (sel == SEL_COUNT);
  assign load_val = reg_wdata[CNT_W-1:0];
  assign w1c_go   = reg_wr && (sel == SEL_STATUS) && reg_wdata[0];

  generate
    if (CNT_W < REG_W) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^reg_wdata[REG_W-1:CNT_W];
    end
  endgenerate

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_COUNT:  rd_mux[CNT_W-1:0] = cur_remaining;
      SEL_STATUS: rd_mux[0]         = cur_done;
      default:    rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cb_pulse_engine.sv
module cb_pulse_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_go,
  input  logic [CNT_W-1:0] load_val,
  output logic             dclk_q,
  output logic             busy_q,
  output logic [CNT_W-1:0] remaining,
  output logic             last_step
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic phase_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      phase_hi  <= 1'b0;
      dclk_q    <= 1'b0;
      busy_q    <= 1'b0;
    end else if (load_go) begin
      remaining <= load_val;
      phase_hi  <= 1'b0;
      dclk_q    <= 1'b0;
      busy_q    <= (load_val != '0);
    end else if (busy_q) begin
      if (!phase_hi) begin
        dclk_q   <= 1'b1;
        phase_hi <= 1'b1;
      end else begin
        dclk_q    <= 1'b0;
        phase_hi  <= 1'b0;
        remaining <= remaining - ONE;
        if (remaining == ONE) busy_q <= 1'b0;
      end
    end
  end

  assign last_step = busy_q && phase_hi && (remaining == ONE);
endmodule

// File: rtl/cb_done_flag.sv
module cb_done_flag #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_go,
  input  logic [CNT_W-1:0] load_val,
  input  logic             last_step,
  input  logic             w1c_go,
  output logic             done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else if (load_go) begin
      done_q <= (load_val == '0);
    end else if (last_step) begin
      done_q <= 1'b1;
    end else if (w1c_go) begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst #(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic              dclk_out,
  output logic              burst_busy
);
  logic             load_go;
  logic [CNT_W-1:0] load_val;
  logic             w1c_go;
  logic [CNT_W-1:0] remaining;
  logic             last_step;
  logic             done_q;

  cb_regif #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_regif (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cur_remaining(remaining),
    .cur_done     (done_q),
    .load_go      (load_go),
    .load_val     (load_val),
    .w1c_go       (w1c_go),
    .reg_rdata    (reg_rdata),
    .reg_rvalid   (reg_rvalid)
  );

  cb_pulse_engine #(.CNT_W(CNT_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .load_go  (load_go),
    .load_val (load_val),
    .dclk_q   (dclk_out),
    .busy_q   (burst_busy),
    .remaining(remaining),
    .last_step(last_step)
  );

  cb_done_flag #(.CNT_W(CNT_W)) u_done (
    .clk      (clk),
    .rst      (rst),
    .load_go  (load_go),
    .load_val (load_val),
    .last_step(last_step),
    .w1c_go   (w1c_go),
    .done_q   (done_q)
  );
endmodule

// File: rtl/cfg_clk_burst_chk.sv
module cfg_clk_burst_chk #(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              reg_rvalid,
  input logic              dclk_out,
  input logic              burst_busy,
  input logic              done_q
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(32'h8);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(32'hC);

  logic cnt_wr, stat_clr, other_rd;
  assign cnt_wr   = reg_wr && (reg_addr == A_COUNT);
  assign stat_clr = reg_wr && (reg_addr == A_STATUS) && reg_wdata[0];
  assign other_rd = reg_rd && (reg_addr != A_COUNT) && (reg_addr != A_STATUS);

  // R3
  dclk_one_high_chk: assert property (@(posedge clk) disable iff (rst)
    dclk_out |=> !dclk_out);

  // R2
  dclk_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    dclk_out |-> burst_busy);

  // R4
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_q && burst_busy));

  // R4
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_busy && !cnt_wr) |=> (burst_busy || done_q));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && reg_wdata[CNT_W-1:0] == '0) |=> (done_q && !burst_busy && !dclk_out));

  // R6
  w1c_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !burst_busy) |=> !done_q);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && reg_wdata[CNT_W-1:0] != '0) |=> (burst_busy && !done_q && !dclk_out));

  // R8
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  // R9
  other_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    other_rd |=> (reg_rdata == '0));
endmodule

bind cfg_clk_burst cfg_clk_burst_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reg_rvalid(reg_rvalid),
  .dclk_out  (dclk_out),
  .burst_busy(burst_busy),
  .done_q    (done_q)
);

// File: tb/cfg_clk_burst_tb.sv
module cfg_clk_burst_tb;
  localparam int ADDR_W = 12;
  localparam int REG_W  = 32;
  localparam logic [ADDR_W-1:0] A_CNT  = 12'h008;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h00C;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              reg_rvalid;
  logic              dclk_out;
  logic              burst_busy;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cfg_clk_burst u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .dclk_out(dclk_out), .burst_busy(burst_busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; reg_addr = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = '0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  // Writes count and checks the whole pulse pattern edge by edge.
  task automatic run_burst(input int n, input string tag);
    int dclk_err = 0, busy_err = 0, done_err = 0, rises = 0;
    logic prev = 1'b0;
    logic [31:0] d; logic v;
    wr(A_CNT, n);
    for (int k = 0; k <= 2*n + 2; k++) begin
      if (k > 0) @(negedge clk);
      if (dclk_out !== ((k % 2 == 1) && (k < 2*n))) dclk_err++;
      if (burst_busy !== (k < 2*n)) busy_err++;
      if (dclk_out && !prev) rises++;
      prev = dclk_out;
    end
    chk("R2", {tag, " pulse count"}, rises, n);
    chk("R3", {tag, " dclk pattern errors"}, dclk_err, 0);
    chk("R4", {tag, " busy pattern errors"}, busy_err, 0);
    rd(A_STAT, d, v);
    if (d !== 32'h1) done_err++;
    chk("R4", {tag, " done after burst"}, done_err, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R1", "dclk after reset", dclk_out, 0);
    chk("R1", "busy after reset", burst_busy, 0);
    rd(A_CNT, d, v);
    chk("R1", "count after reset", d, 0);
    rd(A_STAT, d, v);
    chk("R1", "done after reset", d, 0);
  endtask

  task automatic t_bursts();
    run_burst(4, "n4");
    run_burst(1, "n1");
    run_burst(7, "n7");
  endtask

  task automatic t_w1c();
    logic [31:0] d; logic v;
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, d, v);
    chk("R6", "write 0 keeps done", d, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d, v);
    chk("R6", "write 1 clears done", d, 0);
  endtask

  task automatic t_zero();
    logic [31:0] d; logic v;
    int pulses = 0;
    wr(A_CNT, 0);
    rd(A_STAT, d, v);
    chk("R5", "zero count sets done", d, 1);
    chk("R5", "zero count not busy", burst_busy, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dclk_out || burst_busy) pulses++;
    end
    chk("R5", "zero count no pulses", pulses, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d; logic v;
    wr(A_CNT, 5);
    repeat (3) @(negedge clk);
    chk("R7", "dclk high before restart", dclk_out, 1);
    rd(A_STAT, d, v);
    chk("R7", "done low mid burst", d, 0);
    run_burst(2, "R7 restart");
  endtask

  task automatic t_readback();
    logic [31:0] d; logic v;
    wr(A_CNT, 3);
    rd(A_CNT, d, v);
    chk("R8", "rvalid one clock after strobe", v, 1);
    chk("R8", "remaining at start", d, 3);
    rd(A_CNT, d, v);
    chk("R8", "remaining before first decrement", d, 3);
    rd(A_CNT, d, v);
    chk("R8", "remaining after first pulse", d, 2);
    @(negedge clk);
    chk("R8", "rvalid drops without strobe", reg_rvalid, 0);
    repeat (4) @(negedge clk);
    rd(A_CNT, d, v);
    chk("R8", "remaining at end", d, 0);
    rd(A_STAT, d, v);
    chk("R8", "status reads only bit 0", d, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic v;
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0000_0003);
    chk("R9", "no busy from other offset", burst_busy, 0);
    rd(A_STAT, d, v);
    chk("R9", "done untouched by other offset", d, 1);
    rd(12'h004, d, v);
    chk("R9", "other offset reads 0", d, 0);
    rd(12'h009, d, v);
    chk("R9", "unaligned offset reads 0", d, 0);
  endtask

  task automatic t_trunc();
    logic [31:0] d; logic v;
    run_burst(32'h0001_0002 & 32'h0000_FFFF, "R10 pre");
    wr(A_STAT, 1);
    wr(A_CNT, 32'h0001_0002);
    rd(A_CNT, d, v);
    chk("R10", "upper bits dropped", d, 2);
    repeat (6) @(negedge clk);
    wr(A_STAT, 1);
    wr(A_CNT, 32'h0001_0000);
    chk("R10", "upper-only value not busy", burst_busy, 0);
    rd(A_STAT, d, v);
    chk("R10", "upper-only value counts as zero", d, 1);
  endtask

  task automatic t_set_wins();
    logic [31:0] d; logic v;
    wr(A_CNT, 1);
    @(negedge clk);
    wr(A_STAT, 1);
    rd(A_STAT, d, v);
    chk("R11", "completion beats clear", d, 1);
    wr(A_STAT, 1);
    rd(A_STAT, d, v);
    chk("R11", "later clear works", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bursts();
    t_w1c();
    t_zero();
    t_restart();
    t_readback();
    t_unmapped();
    t_trunc();
    t_set_wins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule